// File: doc/BRIEF.md
# Dual-Key Erase-Protection Unlock

This block holds the erase-protection state of a device and decides when a full-device erase may be started. The protection flag is loaded from a non-volatile configuration input while reset is held and stays fixed until the next reset. While protection is in force, the debugger's ordinary erase-all command does nothing. The only way around it is for both parties to agree: the debugger and the on-chip CPU each write a 32-bit key into their own key register. When both keys are non-zero and equal, the block emits a one-cycle erase start pulse.

The CPU side also has a write-once lock bit. Once the CPU sets it, the CPU key register becomes read-only for the rest of the reset period. Firmware that never expects a debugger unlock can use this to freeze its key early. The debugger reads the protection state through a status register. The erase engine and the non-volatile storage sit outside this block. The block only asserts `erase_start`.

Top module: `erase_unlock_ctrl`

## Requirements
- R1: While `rst_n` is low, both key registers reset to 0 and the lock bit clears to 0, and `erase_start` stays 0. The protection flag is loaded from `nv_protect_en` at every clock edge during reset.
- R2: The debugger key register sits at debugger offset 0x01C. It holds the full 32 bits and reads back the last value written.
- R3: The CPU key register sits at CPU offset 0x504 and reads back the last value accepted. The lock bit reads back at CPU offset 0x500, bit 0.
- R4: `erase_start` is high for exactly one cycle, the cycle after the clock edge on which a key write first makes the two keys equal and non-zero. Writing a key again while the match already holds gives no further pulse. Breaking the match and then restoring it gives a new pulse.
- R5: Two keys that are both zero never count as a match and never raise `erase_start`.
- R6: Writing 1 to CPU offset 0x500 bit 0 sets the lock. Writing 0 never clears it; only reset does. While the lock is set, CPU writes to the key register are dropped without effect. Debugger key writes and matching still work while the lock is set.
- R7: Debugger offset 0x018 bit 0 reads 0 while protection is enabled and 1 while it is not. The flag follows `nv_protect_en` as sampled during reset and does not change until the next reset.
- R8: A debugger write to offset 0x004 with bit 0 set raises `erase_start` for one cycle, in the cycle after the write edge, only while protection is disabled. While protection is enabled, the same write has no effect on `erase_start`. A write to 0x004 with bit 0 clear never has an effect.
- R9: A key match also raises `erase_start` when protection is already disabled.
- R10: Reads of any unmapped offset on either port return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_protect_en | input | 1 | Non-volatile protection setting, sampled during reset (1 = protected) |
| dbg_wr | input | 1 | Debugger write strobe |
| dbg_addr | input | 12 | Debugger register offset |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data (combinational from `dbg_addr`) |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 12 | CPU register offset |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational from `cpu_addr`) |
| erase_start | output | 1 | One-cycle request to start a full erase |

## Verification
The hardest case to reach is a match that completes after the CPU has locked its key. The CPU key must be loaded first. Then the lock is set and a CPU key write is tried and confirmed dropped. A write of 0 to the lock is also tried and confirmed ignored. Only then does the debugger write the frozen value to complete the match. The protection flag changes only across a reset, so the stimulus resets the block a second time with the opposite non-volatile setting. This reaches the unprotected erase command and the unprotected key match in the same run. A behavioural model compares `erase_start` on every clock, which catches extra or missing pulses when an identical key is written again and when a match is broken and then restored.

// File: rtl/erase_unlock_pkg.sv
package erase_unlock_pkg;

   // Register offsets, debugger side
   localparam logic [11:0] EU_DBG_ERASE_CMD = 12'h004;
   localparam logic [11:0] EU_DBG_STATUS    = 12'h018;
   localparam logic [11:0] EU_DBG_KEY       = 12'h01C;

   // Register offsets, CPU side
   localparam logic [11:0] EU_CPU_LOCK      = 12'h500;
   localparam logic [11:0] EU_CPU_KEY       = 12'h504;

   // Encoding of the status bit seen by the debugger
   typedef enum logic {
      EU_PROT_ON  = 1'b0,
      EU_PROT_OFF = 1'b1
   } eu_prot_status_e;

   // Output timing variants of the match detector
   localparam int EU_OUT_COMB = 0;
   localparam int EU_OUT_REG  = 1;

endpackage

// File: rtl/eu_key_reg.sv
module eu_key_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         hold,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   initial begin
      if (W < 1) $fatal(1, "eu_key_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en && !hold)
         q <= wdata;
   end

endmodule

// File: rtl/eu_lock_bit.sv
module eu_lock_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic set_val,
   output logic locked
);

   // Sticky: only a write of 1 changes it, only reset clears it
   always_ff @(posedge clk) begin
      if (!rst_n)
         locked <= 1'b0;
      else if (wr_en && set_val)
         locked <= 1'b1;
   end

endmodule

// File: rtl/eu_match_detect.sv
module eu_match_detect #(
   parameter int W        = 32,
   parameter int OUT_MODE = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] key_a,
   input  logic [W-1:0] key_b,
   input  logic         extra_req,
   output logic         fire
);

   import erase_unlock_pkg::*;

   logic match_now;
   logic match_prev_q;
   logic rise;
   logic fire_pre;

   initial begin
      if (OUT_MODE != EU_OUT_COMB && OUT_MODE != EU_OUT_REG)
         $fatal(1, "eu_match_detect: unsupported OUT_MODE");
   end

   assign match_now = (key_a == key_b) && (|key_a);

   always_ff @(posedge clk) begin
      if (!rst_n)
         match_prev_q <= 1'b0;
      else
         match_prev_q <= match_now;
   end

   assign rise     = match_now && !match_prev_q;
   assign fire_pre = rise || extra_req;

   generate
      if (OUT_MODE == EU_OUT_REG) begin : g_reg_out
         logic fire_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               fire_q <= 1'b0;
            else
               fire_q <= fire_pre;
         end
         assign fire = fire_q;
      end else begin : g_comb_out
         assign fire = fire_pre;
      end
   endgenerate

endmodule

// File: rtl/erase_unlock_ctrl.sv
module erase_unlock_ctrl
   import erase_unlock_pkg::*;
#(
   parameter int              DATA_W     = 32,
   parameter int              ADDR_W     = 12,
   parameter int              OUT_MODE   = EU_OUT_COMB,
   parameter logic [11:0]     OFF_CMD    = EU_DBG_ERASE_CMD,
   parameter logic [11:0]     OFF_STAT   = EU_DBG_STATUS,
   parameter logic [11:0]     OFF_DKEY   = EU_DBG_KEY,
   parameter logic [11:0]     OFF_LOCK   = EU_CPU_LOCK,
   parameter logic [11:0]     OFF_CKEY   = EU_CPU_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nv_protect_en,
   input  logic              dbg_wr,
   input  logic [ADDR_W-1:0] dbg_addr,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic [DATA_W-1:0] dbg_rdata,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              erase_start
);

   localparam int PAD_W = DATA_W - 1;

   initial begin
      if (DATA_W < 2)  $fatal(1, "erase_unlock_ctrl: DATA_W must be at least 2");
      if (ADDR_W < 11) $fatal(1, "erase_unlock_ctrl: ADDR_W too small for offsets");
   end

   // Address decode
   logic dbg_hit_cmd, dbg_hit_stat, dbg_hit_dkey;
   logic cpu_hit_lock, cpu_hit_ckey;

   assign dbg_hit_cmd  = (dbg_addr == ADDR_W'(OFF_CMD));
   assign dbg_hit_stat = (dbg_addr == ADDR_W'(OFF_STAT));
   assign dbg_hit_dkey = (dbg_addr == ADDR_W'(OFF_DKEY));
   assign cpu_hit_lock = (cpu_addr == ADDR_W'(OFF_LOCK));
   assign cpu_hit_ckey = (cpu_addr == ADDR_W'(OFF_CKEY));

   // Protection flag: loaded during reset, frozen afterwards
   logic prot_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         prot_q <= nv_protect_en;
   end

   eu_prot_status_e stat_code;
   assign stat_code = prot_q ? EU_PROT_ON : EU_PROT_OFF;

   // Lock bit
   logic lock_q;
   eu_lock_bit u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cpu_wr && cpu_hit_lock),
      .set_val (cpu_wdata[0]),
      .locked  (lock_q)
   );

   // Key registers
   logic [DATA_W-1:0] key_dbg;
   logic [DATA_W-1:0] key_cpu;

   eu_key_reg #(.W(DATA_W)) u_key_dbg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (dbg_wr && dbg_hit_dkey),
      .hold  (1'b0),
      .wdata (dbg_wdata),
      .q     (key_dbg)
   );

   eu_key_reg #(.W(DATA_W)) u_key_cpu (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cpu_wr && cpu_hit_ckey),
      .hold  (lock_q),
      .wdata (cpu_wdata),
      .q     (key_cpu)
   );

   // Plain erase command, honoured only without protection
   logic cmd_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         cmd_q <= 1'b0;
      else
         cmd_q <= dbg_wr && dbg_hit_cmd && dbg_wdata[0] && !prot_q;
   end

   eu_match_detect #(.W(DATA_W), .OUT_MODE(OUT_MODE)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_a     (key_dbg),
      .key_b     (key_cpu),
      .extra_req (cmd_q),
      .fire      (erase_start)
   );

   // Read muxes
   always_comb begin
      dbg_rdata = '0;
      if (dbg_hit_stat)
         dbg_rdata = {{PAD_W{1'b0}}, logic'(stat_code)};
      else if (dbg_hit_dkey)
         dbg_rdata = key_dbg;
   end

   always_comb begin
      cpu_rdata = '0;
      if (cpu_hit_lock)
         cpu_rdata = {{PAD_W{1'b0}}, lock_q};
      else if (cpu_hit_ckey)
         cpu_rdata = key_cpu;
   end

endmodule

// File: rtl/erase_unlock_ctrl_chk.sv
module erase_unlock_ctrl_chk #(
   parameter int DATA_W   = 32,
   parameter int OUT_MODE = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              erase_start,
   input logic [DATA_W-1:0] key_dbg,
   input logic [DATA_W-1:0] key_cpu,
   input logic              locked,
   input logic              prot
);

   logic m;
   assign m = (key_dbg == key_cpu) && (key_dbg != '0);

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked); // R6

   AST_LOCKED_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(key_cpu)); // R6

   AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(prot)); // R7

   generate
      if (OUT_MODE == 0) begin : g_comb
         AST_MATCH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(m) |-> erase_start); // R4

         AST_PROT_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (erase_start && prot) |-> $rose(m)); // R8

         AST_ZERO_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
            (prot && key_dbg == '0 && key_cpu == '0) |-> !erase_start); // R5
      end else begin : g_reg
         AST_MATCH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(m) |=> erase_start); // R4
      end
   endgenerate

endmodule

bind erase_unlock_ctrl erase_unlock_ctrl_chk #(
   .DATA_W   (DATA_W),
   .OUT_MODE (OUT_MODE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .erase_start (erase_start),
   .key_dbg     (key_dbg),
   .key_cpu     (key_cpu),
   .locked      (lock_q),
   .prot        (prot_q)
);

// File: tb/erase_unlock_ctrl_bench.sv
module erase_unlock_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nv_protect_en = 1'b1;
   logic        dbg_wr = 1'b0;
   logic [11:0] dbg_addr = '0;
   logic [31:0] dbg_wdata = '0;
   logic [31:0] dbg_rdata;
   logic        cpu_wr = 1'b0;
   logic [11:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        erase_start;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   erase_unlock_ctrl u_erase_unlock_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .nv_protect_en (nv_protect_en),
      .dbg_wr        (dbg_wr),
      .dbg_addr      (dbg_addr),
      .dbg_wdata     (dbg_wdata),
      .dbg_rdata     (dbg_rdata),
      .cpu_wr        (cpu_wr),
      .cpu_addr      (cpu_addr),
      .cpu_wdata     (cpu_wdata),
      .cpu_rdata     (cpu_rdata),
      .erase_start   (erase_start)
   );

   // Behavioural reference model, advanced on each rising edge
   logic [31:0] m_dkey, m_ckey;
   bit          m_lock, m_prot, m_prev, m_erase;

   always @(posedge clk) begin
      bit nm, cmd;
      if (!rst_n) begin
         m_dkey = 0; m_ckey = 0; m_lock = 0; m_prev = 0; m_erase = 0;
         m_prot = nv_protect_en;
      end else begin
         cmd = dbg_wr && dbg_addr == 12'h004 && dbg_wdata[0] && !m_prot;
         if (dbg_wr && dbg_addr == 12'h01C) m_dkey = dbg_wdata;
         if (cpu_wr && cpu_addr == 12'h504 && !m_lock) m_ckey = cpu_wdata;
         if (cpu_wr && cpu_addr == 12'h500 && cpu_wdata[0]) m_lock = 1;
         nm = (m_dkey == m_ckey) && (m_dkey != 0);
         m_erase = (nm && !m_prev) || cmd;
         m_prev = nm;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Per-clock comparison of the erase pulse against the model (R4, R8, R9)
   always @(negedge clk) begin
      if (rst_n && !done) check("R4 erase_start vs model", {31'b0, erase_start}, {31'b0, m_erase});
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic dbg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); dbg_wr = 1; dbg_addr = a; dbg_wdata = d;
      @(negedge clk); dbg_wr = 0;
   endtask

   task automatic cpu_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk); cpu_wr = 0;
   endtask

   task automatic dbg_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); dbg_addr = a; #1;
      check(tag, dbg_rdata, exp);
   endtask

   task automatic cpu_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); cpu_addr = a; #1;
      check(tag, cpu_rdata, exp);
   endtask

   task automatic pulse_is(input bit exp, input string tag);
      check(tag, {31'b0, erase_start}, {31'b0, exp});
   endtask

   task automatic do_reset(input bit nv);
      @(negedge clk); rst_n = 0; nv_protect_en = nv;
      repeat (3) @(negedge clk);
      check("R1 erase_start low in reset", {31'b0, erase_start}, 32'h0);
      rst_n = 1;
   endtask

   initial begin
      // Protected device
      do_reset(1'b1);
      dbg_read(12'h018, 32'h0, "R7 status protected");
      dbg_read(12'h01C, 32'h0, "R1 dbg key reset");
      cpu_read(12'h504, 32'h0, "R1 cpu key reset");
      cpu_read(12'h500, 32'h0, "R1 lock reset");

      dbg_write(12'h01C, 32'hA5A5_1234);
      pulse_is(0, "R4 single key no pulse");
      dbg_read(12'h01C, 32'hA5A5_1234, "R2 dbg key readback");
      cpu_write(12'h504, 32'h0000_0001);
      pulse_is(0, "R4 mismatch no pulse");
      cpu_read(12'h504, 32'h0000_0001, "R3 cpu key readback");
      cpu_write(12'h504, 32'hA5A5_1234);
      pulse_is(1, "R4 match pulse");
      @(negedge clk);
      pulse_is(0, "R4 pulse one cycle");
      dbg_write(12'h01C, 32'hA5A5_1234);
      pulse_is(0, "R4 rewrite same key no pulse");
      dbg_write(12'h01C, 32'h0BAD_F00D);
      pulse_is(0, "R4 broken match no pulse");
      dbg_write(12'h01C, 32'hA5A5_1234);
      pulse_is(1, "R4 restored match pulse");

      dbg_write(12'h004, 32'h1);
      pulse_is(0, "R8 erase cmd blocked while protected");

      cpu_write(12'h504, 32'h0);
      dbg_write(12'h01C, 32'h0);
      pulse_is(0, "R5 zero keys no pulse");
      repeat (2) @(negedge clk);
      pulse_is(0, "R5 zero keys stay quiet");

      // Lock sequence
      cpu_write(12'h504, 32'h5EED_0042);
      cpu_write(12'h500, 32'h1);
      cpu_read(12'h500, 32'h1, "R3 lock readback");
      cpu_write(12'h504, 32'h1111_2222);
      cpu_read(12'h504, 32'h5EED_0042, "R6 locked key write dropped");
      cpu_write(12'h500, 32'h0);
      cpu_read(12'h500, 32'h1, "R6 lock not cleared by 0");
      dbg_write(12'h01C, 32'h5EED_0042);
      pulse_is(1, "R6 match with locked cpu key");

      dbg_read(12'h080, 32'h0, "R10 dbg unmapped");
      cpu_read(12'h084, 32'h0, "R10 cpu unmapped");
      dbg_read(12'h018, 32'h0, "R7 status unchanged after match");

      // Unprotected device
      do_reset(1'b0);
      nv_protect_en = 1'b1;
      dbg_read(12'h018, 32'h1, "R7 status unprotected");
      cpu_read(12'h500, 32'h0, "R1 lock cleared by reset");
      cpu_read(12'h504, 32'h0, "R1 cpu key cleared by reset");
      dbg_write(12'h004, 32'h0);
      pulse_is(0, "R8 cmd bit0 clear ignored");
      dbg_write(12'h004, 32'h1);
      pulse_is(1, "R8 erase cmd unprotected");
      @(negedge clk);
      pulse_is(0, "R8 cmd pulse one cycle");
      dbg_read(12'h018, 32'h1, "R7 flag ignores nv after reset");
      cpu_write(12'h504, 32'h7777_0001);
      dbg_write(12'h01C, 32'h7777_0001);
      pulse_is(1, "R9 match while unprotected");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule